// File: doc/BRIEF.md
# Two-Step Egress Timestamp Reporter

This block sits beside a transmit path and watches two points on it. On the client side it observes the packet stream handshake. Each accepted start-of-packet beat places one entry in an in-order queue. The entry records whether the client asked for a two-step timestamp and the 8-bit fingerprint that came with the request. On the line side, a start-of-frame strobe marks the moment each packet reaches the PHY interface. That strobe retires the oldest entry. The block never touches packet data.

When the retired entry carries a request, the block captures the 96-bit time of day and adds the PHY path delay. The path delay arrives as a fixed-point cycle count with ten fractional bits, and the block scales it to nanoseconds using a configured clock period. It then issues a one-cycle report made of the corrected timestamp and the original fingerprint. Software pairs each report with the packet it sent by matching the fingerprint. Packets that carry no request still hold a slot in the queue, so the queue stays aligned with the line-side strobes. A start of packet that arrives while the queue is full is discarded and flagged.

Top module: `ptp_twostep_ts`

## Requirements
- R1: While reset is asserted and after reset is released, `ts_valid_o`, `q_overflow_o`, `ts_o` and `ts_fp_o` are all zero, and the queue is empty.
- R2: An entry is queued only on a cycle where `tx_valid_i`, `tx_ready_i` and `tx_sop_i` are all high. `ts_req_i` and `ts_fp_i` are ignored on every other cycle.
- R3: Each `line_sop_i` cycle with a non-empty queue retires the oldest entry. If that entry carries a request, `ts_valid_o` is high for one cycle, two cycles after the `line_sop_i` cycle, and `ts_fp_o` equals the fingerprint queued with that packet.
- R4: A retired entry without a request produces no report, and the entries behind it keep their order.
- R5: The timestamp has seconds in bits [95:48], nanoseconds in [47:16] and fractional nanoseconds (units of 2^-16 ns) in [15:0]. The reported value is `tod_i` sampled in the `line_sop_i` cycle plus the path delay.
- R6: `path_delay_i` holds whole cycles above bit 10 and fractional cycles in bits [9:0]. The added delay is floor(path_delay_i × CLK_PERIOD_Q16 / 1024) in units of 2^-16 ns, where CLK_PERIOD_Q16 is the clock period in ns times 65536.
- R7: When the corrected nanoseconds reach 10^9 or more, 10^9 is subtracted and the seconds field increments by one.
- R8: The queue holds DEPTH entries. A start of packet that arrives while the queue is full, with no retirement in the same cycle, is dropped, and `q_overflow_o` pulses high in the next cycle. When a retirement happens in the same cycle, the new entry is accepted.
- R9: A `line_sop_i` cycle with an empty queue produces no report and leaves the queue unchanged.
- R10: `ts_o` and `ts_fp_o` keep the last reported values until the next report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_valid_i | input | 1 | Client stream valid |
| tx_ready_i | input | 1 | Client stream ready |
| tx_sop_i | input | 1 | Client start-of-packet beat |
| ts_req_i | input | 1 | Two-step timestamp request, read with the start-of-packet beat |
| ts_fp_i | input | 8 | Fingerprint for the requesting packet |
| line_sop_i | input | 1 | Start of frame at the PHY side, one per packet, in order |
| tod_i | input | 96 | Time of day: seconds, nanoseconds, fractional nanoseconds |
| path_delay_i | input | PD_W | PHY path delay in cycles, with 10 fractional bits |
| ts_valid_o | output | 1 | Report strobe |
| ts_o | output | 96 | Corrected egress timestamp |
| ts_fp_o | output | 8 | Fingerprint of the reported packet |
| q_overflow_o | output | 1 | A start of packet was dropped because the queue was full |

## Verification
Some properties are checked by assertions on every cycle. These are the queue occupancy bound, the hold on a dropped push, the one-entry drop on a retirement, the overflow pulse following a full push, and the rule that retirements without a request or against an empty queue never produce a report. Timestamp arithmetic is different, because its correctness depends on stimulus values. This covers the delay scaling with fractional cycles, the carry into seconds, and fingerprint order across mixed flagged and unflagged packets. Those behaviours are shown only by the bench scenarios, which compare every output against a queue-based model on every clock.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;
  localparam int unsigned FP_W = 8;
  localparam int unsigned TS_W = 96;
  localparam logic [47:0] NS_PER_SEC = 48'd1000000000;

  typedef struct packed {
    logic            req;
    logic [FP_W-1:0] fp;
  } q_entry_t;

  typedef struct packed {
    logic [47:0] sec;
    logic [31:0] ns;
    logic [15:0] frac;
  } tod_t;
endpackage

// File: rtl/ts_fp_queue.sv
module ts_fp_queue #(
  parameter int unsigned DEPTH = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_i,
  input  ptp_ts_pkg::q_entry_t  push_data_i,
  input  logic                  pop_i,
  output ptp_ts_pkg::q_entry_t  head_o,
  output logic                  empty_o,
  output logic                  full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  ptp_ts_pkg::q_entry_t mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic do_pop, do_push;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == DEPTH_C);
  assign head_o  = mem_q[rd_ptr_q];
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full_o | do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q[i] <= '0;
        else if (do_push && wr_ptr_q == AW'(i)) mem_q[i] <= push_data_i;
      end
    end
  endgenerate

  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEPTH_C);
  a_r8_full_push_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> $stable(cnt_q));
  a_r3_pop_retires_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && pop_i && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ts_delay_scale.sv
module ts_delay_scale #(
  parameter int unsigned PD_W           = 24,
  parameter int unsigned PER_W          = 24,
  parameter logic [PER_W-1:0] CLK_PERIOD_Q16 = 24'd419430,
  localparam int unsigned DLY_W = PD_W + PER_W - 10
) (
  input  logic [PD_W-1:0]  path_delay_i,
  output logic [DLY_W-1:0] delay_fns_o
);
  logic [PD_W+PER_W-1:0] prod;
  // cycles (Q10) x ns/cycle (Q16) -> ns Q26, drop 10 bits -> ns Q16
  assign prod        = (PD_W+PER_W)'(path_delay_i) * (PD_W+PER_W)'(CLK_PERIOD_Q16);
  assign delay_fns_o = prod[PD_W+PER_W-1:10];
endmodule

// File: rtl/ts_adjust.sv
module ts_adjust #(
  parameter int unsigned DLY_W = 38
) (
  input  ptp_ts_pkg::tod_t  tod_i,
  input  logic [DLY_W-1:0]  delay_fns_i,
  output ptp_ts_pkg::tod_t  tod_o
);
  logic [63:0] sum;
  logic [47:0] ns_wide;
  logic        carry;

  assign sum     = {16'b0, tod_i.ns, tod_i.frac} + 64'(delay_fns_i);
  assign ns_wide = sum[63:16];
  assign carry   = (ns_wide >= ptp_ts_pkg::NS_PER_SEC);

  always_comb begin
    tod_o.frac = sum[15:0];
    tod_o.ns   = carry ? 32'(ns_wide - ptp_ts_pkg::NS_PER_SEC) : ns_wide[31:0];
    tod_o.sec  = tod_i.sec + {47'b0, carry};
  end
endmodule

// File: rtl/ptp_twostep_ts.sv
module ptp_twostep_ts #(
  parameter int unsigned DEPTH          = 4,
  parameter int unsigned PD_W           = 24,
  parameter int unsigned PER_W          = 24,
  parameter logic [PER_W-1:0] CLK_PERIOD_Q16 = 24'd419430
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tx_valid_i,
  input  logic            tx_ready_i,
  input  logic            tx_sop_i,
  input  logic            ts_req_i,
  input  logic [7:0]      ts_fp_i,
  input  logic            line_sop_i,
  input  logic [95:0]     tod_i,
  input  logic [PD_W-1:0] path_delay_i,
  output logic            ts_valid_o,
  output logic [95:0]     ts_o,
  output logic [7:0]      ts_fp_o,
  output logic            q_overflow_o
);
  import ptp_ts_pkg::*;
  localparam int unsigned DLY_W = PD_W + PER_W - 10;

  logic     push, q_empty, q_full;
  q_entry_t q_head, q_in;

  assign push    = tx_valid_i & tx_ready_i & tx_sop_i;
  assign q_in.req = ts_req_i;
  assign q_in.fp  = ts_fp_i;

  ts_fp_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .push_i(push), .push_data_i(q_in), .pop_i(line_sop_i),
    .head_o(q_head), .empty_o(q_empty), .full_o(q_full)
  );

  logic [DLY_W-1:0] dly_fns;
  ts_delay_scale #(.PD_W(PD_W), .PER_W(PER_W), .CLK_PERIOD_Q16(CLK_PERIOD_Q16)) u_scale (
    .path_delay_i, .delay_fns_o(dly_fns)
  );

  // stage 1: capture egress time, fingerprint and scaled delay
  logic             s1_vld_q;
  tod_t             s1_tod_q, adj_tod;
  logic [7:0]       s1_fp_q;
  logic [DLY_W-1:0] s1_dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s1_tod_q <= '0;
      s1_fp_q  <= '0;
      s1_dly_q <= '0;
    end else begin
      s1_vld_q <= line_sop_i & ~q_empty & q_head.req;
      if (line_sop_i && !q_empty && q_head.req) begin
        s1_tod_q <= tod_t'(tod_i);
        s1_fp_q  <= q_head.fp;
        s1_dly_q <= dly_fns;
      end
    end
  end

  ts_adjust #(.DLY_W(DLY_W)) u_adjust (
    .tod_i(s1_tod_q), .delay_fns_i(s1_dly_q), .tod_o(adj_tod)
  );

  // stage 2: registered report
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_valid_o   <= 1'b0;
      ts_o         <= '0;
      ts_fp_o      <= '0;
      q_overflow_o <= 1'b0;
    end else begin
      ts_valid_o   <= s1_vld_q;
      q_overflow_o <= push & q_full & ~line_sop_i;
      if (s1_vld_q) begin
        ts_o    <= adj_tod;
        ts_fp_o <= s1_fp_q;
      end
    end
  end

  a_r8_overflow_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && q_full && !line_sop_i) |=> q_overflow_o);
  a_r9_empty_no_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_sop_i && q_empty) |=> ##1 !ts_valid_o);
  a_r4_unflagged_no_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_sop_i && !q_empty && !q_head.req) |=> ##1 !ts_valid_o);
  a_r7_ns_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_valid_o |-> (ts_o[47:16] < 32'd1000000000));
endmodule

// File: tb/ptp_twostep_ts_test.sv
module ptp_twostep_ts_test;
  localparam int DEPTH = 4;
  localparam longint PER = 419430;
  localparam longint NS = 1000000000;

  logic clk = 0, rst_n = 0;
  logic tx_valid = 0, tx_ready = 0, tx_sop = 0, ts_req = 0, line_sop = 0;
  logic [7:0] ts_fp = 0;
  logic [95:0] tod = 0;
  logic [23:0] pd = 0;
  logic ts_valid, q_ovf;
  logic [95:0] ts;
  logic [7:0] fp_o;

  int checks = 0, fails = 0;
  bit done = 0;

  ptp_twostep_ts uut (
    .clk_i(clk), .rst_ni(rst_n), .tx_valid_i(tx_valid), .tx_ready_i(tx_ready),
    .tx_sop_i(tx_sop), .ts_req_i(ts_req), .ts_fp_i(ts_fp), .line_sop_i(line_sop),
    .tod_i(tod), .path_delay_i(pd), .ts_valid_o(ts_valid), .ts_o(ts),
    .ts_fp_o(fp_o), .q_overflow_o(q_ovf)
  );

  always #5 clk = ~clk;

  // bench time of day
  longint t_sec = 5, t_ns = 100, t_fr = 0;

  // reference model
  bit [8:0] mq[$];
  bit m_s1_v, e_v, e_ovf;
  bit [95:0] m_s1_ts, e_ts;
  bit [7:0] m_s1_fp, e_fp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); m_s1_v = 0; e_v = 0; e_ovf = 0; e_ts = 0; e_fp = 0;
    end else begin
      bit psh, pp, full;
      bit [8:0] h;
      longint dly, tot, sec;
      psh = tx_valid && tx_ready && tx_sop;
      pp = line_sop && mq.size() > 0;
      full = mq.size() == DEPTH;
      e_v = m_s1_v;
      if (m_s1_v) begin e_ts = m_s1_ts; e_fp = m_s1_fp; end
      e_ovf = psh && full && !line_sop;
      m_s1_v = 0;
      if (pp) begin
        h = mq.pop_front();
        m_s1_v = h[8];
        if (h[8]) begin
          dly = (longint'(pd) * PER) >>> 10;
          tot = ((longint'(tod[47:16])) <<< 16) + longint'(tod[15:0]) + dly;
          sec = longint'(tod[95:48]);
          if ((tot >>> 16) >= NS) begin tot -= NS <<< 16; sec += 1; end
          m_s1_ts = {sec[47:0], tot[47:0]};
          m_s1_fp = h[7:0];
        end
      end
      if (psh && (!full || pp)) mq.push_back({ts_req, ts_fp});
    end
  end

  task automatic chk(bit ok, string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the rising edge
  always @(negedge clk) if (rst_n && !done) begin
    chk(ts_valid === e_v, "R3 ts_valid_o", 96'(ts_valid), 96'(e_v));
    chk(q_ovf === e_ovf, "R8 q_overflow_o", 96'(q_ovf), 96'(e_ovf));
    chk(ts === e_ts, "R5/R10 ts_o", ts, e_ts);
    chk(fp_o === e_fp, "R3/R10 ts_fp_o", 96'(fp_o), 96'(e_fp));
  end

  task automatic step(bit v, bit rdy, bit sop, bit rq, logic [7:0] f, bit ls);
    @(negedge clk);
    tx_valid = v; tx_ready = rdy; tx_sop = sop; ts_req = rq; ts_fp = f; line_sop = ls;
    tod = {t_sec[47:0], t_ns[31:0], t_fr[15:0]};
    t_fr += 16'h2f01;
    if (t_fr >= 65536) begin t_fr -= 65536; t_ns += 1; end
    t_ns += 13;
    if (t_ns >= NS) begin t_ns -= NS; t_sec += 1; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 8'h00, 0);
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pd = 24'h001200;  // 4.5 cycles
    repeat (3) @(negedge clk);
    // R1: outputs zero in reset
    chk(ts_valid === 0 && q_ovf === 0, "R1 flags in reset", 96'({ts_valid, q_ovf}), 0);
    chk(ts === 0 && fp_o === 0, "R1 data in reset", ts, 0);
    rst_n = 1;
    idle(2);
    chk(ts_valid === 0 && ts === 0, "R1 after reset", ts, 0);

    // R3 R5 R6: flagged packets, reports in order
    step(1, 1, 1, 1, 8'h11, 0);
    step(1, 1, 0, 0, 8'h00, 0);
    step(1, 1, 1, 1, 8'h22, 0);
    step(1, 1, 1, 1, 8'h33, 0);
    idle(1);
    step(0, 0, 0, 0, 8'h00, 1);
    pd = 24'hFFFFFF;
    step(0, 0, 0, 0, 8'h00, 1);
    pd = 24'h000001;
    step(0, 0, 0, 0, 8'h00, 1);
    idle(3);

    // R4: unflagged packets between flagged ones
    step(1, 1, 1, 0, 8'hA0, 0);
    step(1, 1, 1, 1, 8'hA1, 0);
    step(1, 1, 1, 0, 8'hA2, 0);
    step(1, 1, 1, 1, 8'hA3, 0);
    pd = 24'h000C00;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 8'h00, 1);
    idle(3);

    // R2: request outside an accepted start beat is ignored
    step(1, 1, 0, 1, 8'hB0, 0);
    step(1, 0, 1, 1, 8'hB1, 0);
    step(0, 1, 1, 1, 8'hB2, 0);
    idle(1);
    // R9: queue should be empty, retirement gives no report
    step(0, 0, 0, 0, 8'h00, 1);
    idle(3);
    chk(ts_valid === 0, "R2/R9 no report", 96'(ts_valid), 0);

    // R7: carry into seconds
    t_ns = NS - 20; t_fr = 16'hF000;
    step(1, 1, 1, 1, 8'hC7, 0);
    pd = 24'h001000;  // 4 cycles = 25.6 ns
    step(0, 0, 0, 0, 8'h00, 1);
    idle(3);

    // R8: overflow, then push with simultaneous pop when full
    pd = 24'h000400;
    for (int i = 0; i < DEPTH; i++) step(1, 1, 1, 1, 8'(8'hD0 + i), 0);
    step(1, 1, 1, 1, 8'hDF, 0);      // dropped
    idle(1);
    chk(q_ovf === 1, "R8 overflow pulse", 96'(q_ovf), 1);
    idle(1);
    chk(q_ovf === 0, "R8 overflow single cycle", 96'(q_ovf), 0);
    step(1, 1, 1, 1, 8'hE0, 1);      // full, pop+push accepted
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 8'h00, 1);
    step(0, 0, 0, 0, 8'h00, 1);      // R9: empty again
    idle(4);

    // back-to-back reports and push into empty with same-cycle line strobe
    step(1, 1, 1, 1, 8'h51, 1);
    step(1, 1, 1, 1, 8'h52, 1);
    step(0, 0, 0, 0, 8'h00, 1);
    idle(5);
    chk(ts_fp_o_hold(), "R10 fingerprint held", 96'(fp_o), 96'(8'h52));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic bit ts_fp_o_hold();
    return fp_o === 8'h52;
  endfunction
endmodule